// File: doc/BRIEF.md
# Hierarchical Interrupt Status Aggregator

This block gathers event pulses from the transmit path, the per-group overflow monitors and the per-link overflow monitors, and latches them into status registers. A register port lets a processor read and update them. Each source has an enable bit. The enabled sources are reduced through two levels, group or link first and then a top-level status word, into one registered, active-high interrupt line.

Group overflows are summarised twice. Each group has five sticky sources, and these reduce to one bit per group in a read-only summary word. That word then reduces to a single top-level bit. A handler reads the top word, then the group summary, then one group's status register: three reads in all. The top-level overflow bit cannot be cleared by a write. It drops only when the underlying status is cleared or its enables are removed.

Transmit control-cell completions and reference-link frame ends from all groups share one top-level bit. A group contributes to that bit only when both its cell-transfer enable and its frame-end enable are set. All latched bits are cleared by writing 0 to them. A write of 1 leaves a bit as it is.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every status and enable register reads 0 and `irq` is 0.
- R2: A pulse on bit s of group g's overflow input sets bit s of that group's status register (address 0x08+g, bits 4:0). The bit stays set until software clears it.
- R3: Bit g of the read-only group summary (address 0x02) is 1 when group g has any status bit whose enable bit (address 0x10+g) is also set. Top-level status bit 8 (address 0x00) is the OR of the summary bits.
- R4: A write to top-level status bit 8 does not clear it. Clearing the group enables, or the group status, clears it.
- R5: A link overflow pulse sets the matching bit of that link's 13-bit status register (address 0x18+l). Bit 12 is the FIFO overflow, bits 11:8 are the input counters, bits 7:4 are the transmit counters and bits 3:0 are the receive counters. Top-level bit l is 1 when that link has any status bit whose enable bit (address 0x1C+l) is also set.
- R6: Writing 0 to a latched status bit clears it. Writing 1 leaves it unchanged.
- R7: A cell-transfer-done pulse for group g sets bit g of the ready register (address 0x03). Top-level bit 7 is 1 only if some group g has a latched ready or frame-end bit and has both cell enable bit g (address 0x05) and frame enable bit g (address 0x06) set.
- R8: A frame-end pulse for group g sets bit g of the frame register (address 0x04). Software clears it by writing 0.
- R9: A pulse on the auxiliary event input sets top-level bit 6. Bit 6 is cleared by writing 0 to bit 6 of address 0x00.
- R10: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R11: One cycle after the status and enable registers change, `irq` equals the OR of top-level status ANDed with the top-level enable register (address 0x01).
- R12: Reads have no side effects. Writes to the group summary and to top-level bits 8, 7 and 3:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_ovf_ev | input | NUM_GRP*5 | Group overflow pulses, group g in bits [5g+4:5g] |
| link_ovf_ev | input | NUM_LINK*13 | Link overflow pulses, link l in bits [13l+12:13l] |
| cell_done_ev | input | NUM_GRP | Control-cell transfer complete, one per group |
| frame_end_ev | input | NUM_GRP | End of frame on a group's reference link |
| aux_ev | input | 1 | Auxiliary event for top-level bit 6 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq | output | 1 | Registered interrupt, active high |

## Verification
On every cycle, the assertions check several things. Latched bits never drop without a write. A pulse always lands in its status bit, even when a clear arrives in the same cycle. The overflow summary falls whenever its enables are all zero. The shared transmit bit never appears without both enables of some group. The interrupt line follows the previous cycle's enabled status. Only the bench scenarios can show the register map and the bit positions of each source. They also show that writes to summary bits are ignored and that writing 1 preserves a bit. Finally, they show that the interrupt is released once software masks or clears the source.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int GRP_SRC = 5;
    localparam int LINK_SRC = 13;
    localparam int TOP_W = 9;

    localparam int A_TOP_STAT  = 'h00;
    localparam int A_TOP_EN    = 'h01;
    localparam int A_GRP_SUM   = 'h02;
    localparam int A_TX_READY  = 'h03;
    localparam int A_TX_FRAME  = 'h04;
    localparam int A_CELL_EN   = 'h05;
    localparam int A_FRAME_EN  = 'h06;
    localparam int A_GRP_STAT  = 'h08;
    localparam int A_GRP_EN    = 'h10;
    localparam int A_LINK_STAT = 'h18;
    localparam int A_LINK_EN   = 'h1C;

    localparam int TB_GRP_OVF = 8;
    localparam int TB_TX_EVT  = 7;
    localparam int TB_AUX     = 6;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int W  = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  ev,
    input  logic          stat_wr,
    input  logic          en_wr,
    input  logic [DW-1:0] wdata,
    output logic [W-1:0]  stat,
    output logic [W-1:0]  en,
    output logic          sum
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_wr) st_d.stat = st_q.stat & wdata[W-1:0];
        st_d.stat = st_d.stat | ev;
        if (en_wr) st_d.en = wdata[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;
    assign en   = st_q.en;
    assign sum  = |(st_q.stat & st_q.en);

    // R2: latched bits hold unless written
    assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_wr) |-> ((stat & $past(stat)) == $past(stat)));
    // R10: an event always lands, even against a clear
    assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((stat & $past(ev)) == $past(ev)));
endmodule

// File: rtl/irq_tx_events.sv
module irq_tx_events #(
    parameter int NG = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NG-1:0] cell_ev,
    input  logic [NG-1:0] frame_ev,
    input  logic          rdy_wr,
    input  logic          frm_wr,
    input  logic          cen_wr,
    input  logic          fen_wr,
    input  logic [DW-1:0] wdata,
    output logic [NG-1:0] ready,
    output logic [NG-1:0] frame,
    output logic [NG-1:0] cell_en,
    output logic [NG-1:0] frame_en,
    output logic [NG-1:0] hit
);
    typedef struct packed {
        logic [NG-1:0] ready;
        logic [NG-1:0] frame;
        logic [NG-1:0] cen;
        logic [NG-1:0] fen;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (rdy_wr) tx_d.ready = tx_q.ready & wdata[NG-1:0];
        if (frm_wr) tx_d.frame = tx_q.frame & wdata[NG-1:0];
        tx_d.ready = tx_d.ready | cell_ev;
        tx_d.frame = tx_d.frame | frame_ev;
        if (cen_wr) tx_d.cen = wdata[NG-1:0];
        if (fen_wr) tx_d.fen = wdata[NG-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign ready    = tx_q.ready;
    assign frame    = tx_q.frame;
    assign cell_en  = tx_q.cen;
    assign frame_en = tx_q.fen;
    assign hit      = (tx_q.ready | tx_q.frame) & tx_q.cen & tx_q.fen;

    // R8: a frame-end pulse is always latched
    assert_frame_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ev != '0) |=> ((frame & $past(frame_ev)) == $past(frame_ev)));
    // R7: a ready bit is always latched
    assert_ready_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_ev != '0) |=> ((ready & $past(cell_ev)) == $past(cell_ev)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_GRP  = 8,
    parameter int NUM_LINK = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_GRP*GRP_SRC-1:0]   grp_ovf_ev,
    input  logic [NUM_LINK*LINK_SRC-1:0] link_ovf_ev,
    input  logic [NUM_GRP-1:0]           cell_done_ev,
    input  logic [NUM_GRP-1:0]           frame_end_ev,
    input  logic                         aux_ev,
    input  logic                         reg_wr,
    input  logic [AW-1:0]                reg_addr,
    input  logic [DW-1:0]                reg_wdata,
    output logic [DW-1:0]                reg_rdata,
    output logic                         irq
);
    initial begin
        if (NUM_GRP > 8 || NUM_LINK > 4 || NUM_LINK < 1 || NUM_GRP < 1)
            $error("irq_aggregator: group or link count out of range");
    end

    logic [GRP_SRC-1:0]  grp_stat [NUM_GRP];
    logic [GRP_SRC-1:0]  grp_en   [NUM_GRP];
    logic [NUM_GRP-1:0]  grp_sum;
    logic [LINK_SRC-1:0] link_stat [NUM_LINK];
    logic [LINK_SRC-1:0] link_en   [NUM_LINK];
    logic [NUM_LINK-1:0] link_sum;
    logic [NUM_GRP-1:0]  tx_ready, tx_frame, tx_cen, tx_fen, tx_hit;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        irq_sticky_bank #(.W(GRP_SRC), .DW(DW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      (grp_ovf_ev[g*GRP_SRC +: GRP_SRC]),
            .stat_wr (reg_wr && reg_addr == AW'(A_GRP_STAT + g)),
            .en_wr   (reg_wr && reg_addr == AW'(A_GRP_EN + g)),
            .wdata   (reg_wdata),
            .stat    (grp_stat[g]),
            .en      (grp_en[g]),
            .sum     (grp_sum[g])
        );
    end

    for (genvar l = 0; l < NUM_LINK; l++) begin : g_link
        irq_sticky_bank #(.W(LINK_SRC), .DW(DW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      (link_ovf_ev[l*LINK_SRC +: LINK_SRC]),
            .stat_wr (reg_wr && reg_addr == AW'(A_LINK_STAT + l)),
            .en_wr   (reg_wr && reg_addr == AW'(A_LINK_EN + l)),
            .wdata   (reg_wdata),
            .stat    (link_stat[l]),
            .en      (link_en[l]),
            .sum     (link_sum[l])
        );
    end

    irq_tx_events #(.NG(NUM_GRP), .DW(DW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cell_ev  (cell_done_ev),
        .frame_ev (frame_end_ev),
        .rdy_wr   (reg_wr && reg_addr == AW'(A_TX_READY)),
        .frm_wr   (reg_wr && reg_addr == AW'(A_TX_FRAME)),
        .cen_wr   (reg_wr && reg_addr == AW'(A_CELL_EN)),
        .fen_wr   (reg_wr && reg_addr == AW'(A_FRAME_EN)),
        .wdata    (reg_wdata),
        .ready    (tx_ready),
        .frame    (tx_frame),
        .cell_en  (tx_cen),
        .frame_en (tx_fen),
        .hit      (tx_hit)
    );

    typedef struct packed {
        logic             aux;
        logic [TOP_W-1:0] en;
        logic             irq;
    } top_t;

    top_t top_d, top_q;
    logic [TOP_W-1:0] top_stat;

    always_comb begin
        top_stat = '0;
        top_stat[NUM_LINK-1:0] = link_sum;
        top_stat[TB_AUX]     = top_q.aux;
        top_stat[TB_TX_EVT]  = |tx_hit;
        top_stat[TB_GRP_OVF] = |grp_sum;
    end

    always_comb begin
        top_d = top_q;
        if (reg_wr && reg_addr == AW'(A_TOP_STAT) && !reg_wdata[TB_AUX])
            top_d.aux = 1'b0;
        if (aux_ev) top_d.aux = 1'b1;
        if (reg_wr && reg_addr == AW'(A_TOP_EN))
            top_d.en = reg_wdata[TOP_W-1:0];
        top_d.irq = |(top_stat & top_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign irq = top_q.irq;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(A_TOP_STAT): reg_rdata = DW'(top_stat);
            AW'(A_TOP_EN):   reg_rdata = DW'(top_q.en);
            AW'(A_GRP_SUM):  reg_rdata = DW'(grp_sum);
            AW'(A_TX_READY): reg_rdata = DW'(tx_ready);
            AW'(A_TX_FRAME): reg_rdata = DW'(tx_frame);
            AW'(A_CELL_EN):  reg_rdata = DW'(tx_cen);
            AW'(A_FRAME_EN): reg_rdata = DW'(tx_fen);
            default: begin
                for (int g = 0; g < NUM_GRP; g++) begin
                    if (reg_addr == AW'(A_GRP_STAT + g)) reg_rdata = DW'(grp_stat[g]);
                    if (reg_addr == AW'(A_GRP_EN + g))   reg_rdata = DW'(grp_en[g]);
                end
                for (int l = 0; l < NUM_LINK; l++) begin
                    if (reg_addr == AW'(A_LINK_STAT + l)) reg_rdata = DW'(link_stat[l]);
                    if (reg_addr == AW'(A_LINK_EN + l))   reg_rdata = DW'(link_en[l]);
                end
            end
        endcase
    end

    logic any_grp_en;
    always_comb begin
        any_grp_en = 1'b0;
        for (int g = 0; g < NUM_GRP; g++) any_grp_en = any_grp_en | (|grp_en[g]);
    end

    // R4: overflow summary is released once every group enable is cleared
    assert_ovf_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !any_grp_en |-> !top_stat[TB_GRP_OVF]);
    // R7: shared transmit bit needs both enables of some group
    assert_tx_both_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        top_stat[TB_TX_EVT] |-> ((tx_cen & tx_fen) != '0));
    // R11: interrupt follows previous cycle's enabled status
    assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ($past(top_stat & top_q.en) != '0));
    // R9: aux bit holds unless written
    assert_aux_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(top_q.aux) && !$past(reg_wr)) |-> top_q.aux);
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 8;
    localparam int NL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NG*5-1:0]  grp_ovf_ev = '0;
    logic [NL*13-1:0] link_ovf_ev = '0;
    logic [NG-1:0]    cell_done_ev = '0;
    logic [NG-1:0]    frame_end_ev = '0;
    logic             aux_ev = 1'b0;
    logic             reg_wr = 1'b0;
    logic [5:0]       reg_addr = '0;
    logic [15:0]      reg_wdata = '0;
    logic [15:0]      reg_rdata;
    logic             irq;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_aggregator #(.NUM_GRP(NG), .NUM_LINK(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .grp_ovf_ev(grp_ovf_ev), .link_ovf_ev(link_ovf_ev),
        .cell_done_ev(cell_done_ev), .frame_end_ev(frame_end_ev), .aux_ev(aux_ev),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [15:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_check("R1 top stat", 6'h00, 16'h0);
        rd_check("R1 top en", 6'h01, 16'h0);
        rd_check("R1 grp3 stat", 6'h0B, 16'h0);
        rd_check("R1 link2 en", 6'h1E, 16'h0);
        check("R1 irq", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_group();
        @(negedge clk); grp_ovf_ev[3*5+2] = 1'b1;
        @(negedge clk); grp_ovf_ev = '0;
        rd_check("R2 grp3 stat", 6'h0B, 16'h0004);
        tick(); tick();
        rd_check("R2 sticky", 6'h0B, 16'h0004);
        rd_check("R3 sum masked", 6'h02, 16'h0000);
        wr(6'h13, 16'h0004);
        rd_check("R3 grp sum", 6'h02, 16'h0008);
        rd_check("R3 top bit8", 6'h00, 16'h0100);
        wr(6'h02, 16'h0000);
        rd_check("R12 sum write ignored", 6'h02, 16'h0008);
        wr(6'h00, 16'h0000);
        rd_check("R4 bit8 survives write", 6'h00, 16'h0100);
        wr(6'h13, 16'h0000);
        rd_check("R4 bit8 cleared by mask", 6'h00, 16'h0000);
        rd_check("R4 status kept", 6'h0B, 16'h0004);
        wr(6'h0B, 16'h001B);
        rd_check("R6 grp w0c", 6'h0B, 16'h0000);
    endtask

    task automatic t_link();
        @(negedge clk); link_ovf_ev[1*13+12] = 1'b1; link_ovf_ev[1*13+5] = 1'b1;
        @(negedge clk); link_ovf_ev = '0;
        rd_check("R5 link1 stat", 6'h19, 16'h1020);
        wr(6'h1D, 16'h1000);
        rd_check("R5 top bit1", 6'h00, 16'h0002);
        wr(6'h19, 16'hEFFF);
        rd_check("R6 clear bit12 only", 6'h19, 16'h0020);
        rd_check("R6 top bit1 low", 6'h00, 16'h0000);
        wr(6'h19, 16'hFFFF);
        rd_check("R6 write ones keeps", 6'h19, 16'h0020);
        wr(6'h19, 16'h0000);
        wr(6'h1D, 16'h0000);
    endtask

    task automatic t_tx();
        @(negedge clk); cell_done_ev[2] = 1'b1;
        @(negedge clk); cell_done_ev = '0;
        rd_check("R7 ready", 6'h03, 16'h0004);
        wr(6'h05, 16'h0004);
        rd_check("R7 one enable only", 6'h00, 16'h0000);
        wr(6'h06, 16'h0004);
        rd_check("R7 both enables", 6'h00, 16'h0080);
        wr(6'h03, 16'h00FB);
        rd_check("R7 ready cleared", 6'h00, 16'h0000);
        @(negedge clk); frame_end_ev[5] = 1'b1;
        @(negedge clk); frame_end_ev = '0;
        rd_check("R8 frame latched", 6'h04, 16'h0020);
        rd_check("R8 not enabled grp5", 6'h00, 16'h0000);
        wr(6'h04, 16'h0000);
        rd_check("R8 frame cleared", 6'h04, 16'h0000);
    endtask

    task automatic t_aux_irq();
        @(negedge clk); aux_ev = 1'b1;
        @(negedge clk); aux_ev = 1'b0;
        rd_check("R9 aux set", 6'h00, 16'h0040);
        check("R11 masked no irq", {15'b0, irq}, 16'h0);
        wr(6'h01, 16'h0040);
        check("R11 irq lag", {15'b0, irq}, 16'h0);
        tick();
        check("R11 irq raised", {15'b0, irq}, 16'h1);
        wr(6'h00, 16'hFFBF);
        rd_check("R9 aux cleared", 6'h00, 16'h0000);
        tick();
        check("R11 irq released", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_priority();
        @(negedge clk); link_ovf_ev[0] = 1'b1;
        @(negedge clk); link_ovf_ev = '0;
        @(negedge clk);
        link_ovf_ev[0] = 1'b1; link_ovf_ev[3] = 1'b1;
        reg_wr = 1'b1; reg_addr = 6'h18; reg_wdata = 16'h0000;
        @(negedge clk);
        link_ovf_ev = '0; reg_wr = 1'b0;
        rd_check("R10 event beats clear", 6'h18, 16'h0009);
        @(negedge clk); aux_ev = 1'b1;
        reg_wr = 1'b1; reg_addr = 6'h00; reg_wdata = 16'h0000;
        @(negedge clk); aux_ev = 1'b0; reg_wr = 1'b0;
        rd_check("R10 aux beats clear", 6'h00, 16'h0040);
        rd_check("R12 read no side effect", 6'h00, 16'h0040);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_group();
        t_link();
        t_tx();
        t_aux_irq();
        t_priority();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule